// File: doc/BRIEF.md
# Planar Video Memory Write Masking Unit

This block sits between a processor bus and a video frame buffer built from four byte-wide planes that share one address. Each frame buffer read copies all four plane bytes into the block's per-plane data latches. Each processor write produces four plane bytes and four per-plane write strobes. The bytes mix fresh data with the latched bytes under an 8-bit bit mask. Four write modes decide what the fresh data is: the processor byte itself, a copy of the latch contents, one processor bit spread over a whole byte, or a colour bit spread over a byte and gated by the processor byte.

A read can also be run as a colour compare. It then returns, for each of the eight pixel positions, whether the pixel across the included planes equals a 4-bit reference colour. A don't-care register picks which planes take part. Settings are loaded through an index/data port: one write selects a register and the following data writes load it.

Top module: `vplane_wmask`

## Requirements
- R1: After reset the bit mask is FFh, the don't-care bits, the reference colour, the read-plane select and the write mode are all 0, and all four data latches hold 00h.
- R2: A configuration write with `cfg_sel`=0 stores `cfg_wdata[2:0]` as the register index. One with `cfg_sel`=1 loads the indexed register. Index 0 is the bit mask (8 bits), 1 is don't-care (bits 3:0), 2 is the reference colour (bits 3:0), 3 is the write mode (bits 1:0) and 4 is the read-plane select (bits 1:0). The index stays until it is rewritten, and data writes to indices 5 to 7 change nothing.
- R3: In write modes 0, 2 and 3, every plane takes the fresh bit where the bit-mask bit is 1 and the latched bit where it is 0.
- R4: A frame buffer read (`rd_en`=1, normal or compare) loads all four latches from `rd_planes` at the clock edge that ends the read cycle. Writes in later cycles use the new values, and writes before any later read keep using the old values.
- R5: In write mode 1, each plane's output byte equals its latch byte and the bit mask has no effect.
- R6: In write mode 0, the fresh byte for every plane is `wr_data`.
- R7: In write mode 2, the fresh byte for plane n is bit n of `wr_data` copied to all eight positions.
- R8: In write mode 3, the fresh byte for plane n is bit n of the reference colour copied to all eight positions, ANDed with `wr_data`.
- R9: `fb_we` equals `map_mask` while `wr_en` is 1 and is 0000b otherwise, so a plane whose map-mask bit is 0 keeps its contents whatever the bit mask holds.
- R10: With `rd_cmp`=1, bit i of `rd_result` is 1 when, for every plane n whose don't-care bit is 1, bit i of plane n equals colour bit n. With no plane included every bit is 1. Bits 7:4 of the don't-care data have no effect.
- R11: With `rd_cmp`=0, `rd_result` is the plane byte picked by the read-plane select. Plane n occupies bits 8n+7:8n of `rd_planes` and `fb_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the index, 1 writes the indexed register |
| cfg_wdata | input | 8 | Configuration write data |
| rd_en | input | 1 | Frame buffer read in this cycle; loads the latches |
| rd_cmp | input | 1 | Read returns the colour-compare result |
| rd_planes | input | 32 | Four plane bytes returned by the frame buffer |
| rd_result | output | 8 | Read data or compare result |
| wr_en | input | 1 | Processor write in this cycle |
| wr_data | input | 8 | Processor write byte |
| map_mask | input | 4 | Planes allowed to receive this write |
| fb_we | output | 4 | Per-plane write strobes |
| fb_wdata | output | 32 | Per-plane write bytes |

## Verification
The checker keeps its own copy of the bit mask, the write mode, the don't-care bits and the last read data, all rebuilt from the configuration and read ports. It therefore assumes that every register change goes through that port and that the latches change only on reads. It also treats a read and a write in the same cycle as using the latch values from before that read. The stimulus never asserts `rd_en` and `wr_en` together. Every read returns the bench's own four-plane memory image, so the masked-write checks always compare against the byte the latch should hold.

// File: rtl/vplane_wmask_pkg.sv
package vplane_wmask_pkg;
    parameter int NUM_PLANES = 4;
    parameter int BYTE_W     = 8;
    parameter int IDX_W      = 3;
    localparam int MAP_W     = $clog2(NUM_PLANES);
    localparam int BUS_W     = NUM_PLANES * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [NUM_PLANES-1:0] planes_t;

    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_LATCH  = 2'd1,
        WM_EXPAND = 2'd2,
        WM_COLOR  = 2'd3
    } wmode_e;

    typedef enum logic [IDX_W-1:0] {
        IX_BITMASK  = 3'd0,
        IX_DONTCARE = 3'd1,
        IX_COLOR    = 3'd2,
        IX_MODE     = 3'd3,
        IX_RDMAP    = 3'd4
    } idx_e;

    typedef struct packed {
        byte_t                 bit_mask;
        logic [NUM_PLANES-1:0] dont_care;
        logic [NUM_PLANES-1:0] color;
        wmode_e                mode;
        logic [MAP_W-1:0]      rd_map;
    } cfg_t;

    function automatic byte_t merge_bits(byte_t fresh, byte_t held, byte_t mask);
        return (fresh & mask) | (held & ~mask);
    endfunction
endpackage

// File: rtl/wm_cfg_regs.sv
module wm_cfg_regs
    import vplane_wmask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  byte_t       cfg_wdata,
    output cfg_t        cfg
);
    idx_e cur_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx       <= IX_BITMASK;
            cfg.bit_mask  <= '1;
            cfg.dont_care <= '0;
            cfg.color     <= '0;
            cfg.mode      <= WM_DIRECT;
            cfg.rd_map    <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                cur_idx <= idx_e'(cfg_wdata[IDX_W-1:0]);
            end else begin
                case (cur_idx)
                    IX_BITMASK:  cfg.bit_mask  <= cfg_wdata;
                    IX_DONTCARE: cfg.dont_care <= cfg_wdata[NUM_PLANES-1:0];
                    IX_COLOR:    cfg.color     <= cfg_wdata[NUM_PLANES-1:0];
                    IX_MODE:     cfg.mode      <= wmode_e'(cfg_wdata[1:0]);
                    IX_RDMAP:    cfg.rd_map    <= cfg_wdata[MAP_W-1:0];
                    default:     ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wm_latches.sv
module wm_latches
    import vplane_wmask_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_en,
    input  planes_t rd_pl,
    output planes_t latch
);
    always_ff @(posedge clk) begin
        if (rst)        latch <= '0;
        else if (rd_en) latch <= rd_pl;
    end
endmodule

// File: rtl/wm_plane_merge.sv
module wm_plane_merge
    import vplane_wmask_pkg::*;
#(
    parameter int PLANE = 0
) (
    input  wmode_e mode,
    input  byte_t  bit_mask,
    input  logic   color_bit,
    input  byte_t  wr_data,
    input  byte_t  latch_byte,
    output byte_t  out_byte
);
    byte_t fresh;

    always_comb begin
        case (mode)
            WM_EXPAND: fresh = {BYTE_W{wr_data[PLANE]}};
            WM_COLOR:  fresh = {BYTE_W{color_bit}} & wr_data;
            default:   fresh = wr_data;
        endcase
        if (mode == WM_LATCH) out_byte = latch_byte;
        else                  out_byte = merge_bits(fresh, latch_byte, bit_mask);
    end
endmodule

// File: rtl/wm_compare.sv
module wm_compare
    import vplane_wmask_pkg::*;
(
    input  planes_t               rd_pl,
    input  logic [NUM_PLANES-1:0] dont_care,
    input  logic [NUM_PLANES-1:0] color,
    output byte_t                 match
);
    always_comb begin
        for (int i = 0; i < BYTE_W; i++) begin
            match[i] = 1'b1;
            for (int m = 0; m < NUM_PLANES; m++) begin
                if (dont_care[m] && (rd_pl[m][i] != color[m])) match[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vplane_wmask.sv
module vplane_wmask
    import vplane_wmask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        rd_en,
    input  logic        rd_cmp,
    input  logic [31:0] rd_planes,
    output logic [7:0]  rd_result,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  map_mask,
    output logic [3:0]  fb_we,
    output logic [31:0] fb_wdata
);
    cfg_t    cfg;
    planes_t rd_pl;
    planes_t latch;
    planes_t wr_pl;
    byte_t   cmp_res;

    assign rd_pl = planes_t'(rd_planes);

    wm_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    wm_latches u_latch (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .rd_pl (rd_pl),
        .latch (latch)
    );

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        wm_plane_merge #(.PLANE(p)) u_merge (
            .mode       (cfg.mode),
            .bit_mask   (cfg.bit_mask),
            .color_bit  (cfg.color[p]),
            .wr_data    (wr_data),
            .latch_byte (latch[p]),
            .out_byte   (wr_pl[p])
        );
    end

    wm_compare u_cmp (
        .rd_pl     (rd_pl),
        .dont_care (cfg.dont_care),
        .color     (cfg.color),
        .match     (cmp_res)
    );

    assign fb_wdata  = wr_pl;
    assign fb_we     = wr_en ? map_mask : '0;
    assign rd_result = rd_cmp ? cmp_res : rd_pl[cfg.rd_map];
endmodule

// File: rtl/vplane_wmask_chk.sv
module vplane_wmask_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        cfg_sel,
    input logic [7:0]  cfg_wdata,
    input logic        rd_en,
    input logic        rd_cmp,
    input logic [31:0] rd_planes,
    input logic [7:0]  rd_result,
    input logic        wr_en,
    input logic [3:0]  map_mask,
    input logic [3:0]  fb_we,
    input logic [31:0] fb_wdata
);
    logic [2:0]  sh_idx;
    logic [7:0]  sh_mask;
    logic [1:0]  sh_mode;
    logic [3:0]  sh_dc;
    logic [31:0] sh_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_idx  <= '0;
            sh_mask <= 8'hFF;
            sh_mode <= '0;
            sh_dc   <= '0;
            sh_last <= '0;
        end else begin
            if (cfg_we && !cfg_sel) sh_idx <= cfg_wdata[2:0];
            if (cfg_we && cfg_sel && sh_idx == 3'd0) sh_mask <= cfg_wdata;
            if (cfg_we && cfg_sel && sh_idx == 3'd1) sh_dc   <= cfg_wdata[3:0];
            if (cfg_we && cfg_sel && sh_idx == 3'd3) sh_mode <= cfg_wdata[1:0];
            if (rd_en) sh_last <= rd_planes;
        end
    end

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> fb_we == 4'b0000);                                        // R9
    AST_STROBE_IN_MAP: assert property (@(posedge clk) disable iff (rst)
        (fb_we & ~map_mask) == 4'b0000);                                      // R9
    AST_MASKED_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sh_mode != 2'd1) |-> ((fb_wdata ^ sh_last) & ~{4{sh_mask}}) == 32'h0); // R3
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sh_mode == 2'd1) |-> fb_wdata == sh_last);                  // R5
    AST_EMPTY_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_cmp && sh_dc == 4'b0000) |-> rd_result == 8'hFF);        // R10
endmodule

bind vplane_wmask vplane_wmask_chk u_chk (.*);

// File: tb/test_vplane_wmask.sv
`timescale 1ns/1ps
module test_vplane_wmask;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_sel;
    logic [7:0]  cfg_wdata;
    logic        rd_en, rd_cmp;
    logic [31:0] rd_planes;
    logic [7:0]  rd_result;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [3:0]  map_mask;
    logic [3:0]  fb_we;
    logic [31:0] fb_wdata;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  m_idx;
    logic [7:0]  m_mask;
    logic [3:0]  m_dc, m_col;
    logic [1:0]  m_mode, m_rdmap;
    logic [31:0] m_latch, m_mem;

    always #4 clk = ~clk;

    vplane_wmask i_vplane_wmask (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_en(rd_en), .rd_cmp(rd_cmp), .rd_planes(rd_planes), .rd_result(rd_result),
        .wr_en(wr_en), .wr_data(wr_data), .map_mask(map_mask),
        .fb_we(fb_we), .fb_wdata(fb_wdata)
    );

    function automatic logic [31:0] exp_write(logic [1:0] md, logic [7:0] msk, logic [3:0] col,
                                              logic [31:0] lat, logic [7:0] d);
        logic [31:0] r;
        for (int p = 0; p < 4; p++) begin
            logic [7:0] src;
            logic [7:0] old;
            old = lat[8*p +: 8];
            if (md == 2'd0)      src = d;
            else if (md == 2'd2) src = {8{d[p]}};
            else                 src = {8{col[p]}} & d;
            if (md == 2'd1) r[8*p +: 8] = old;
            else            r[8*p +: 8] = (src & msk) | (old & ~msk);
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_cmp(logic [31:0] pl, logic [3:0] dc, logic [3:0] col);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = 1'b1;
            for (int m = 0; m < 4; m++)
                if (dc[m] && pl[8*m + i] != col[m]) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        rd_en = 0; rd_cmp = 0; rd_planes = 0;
        wr_en = 0; wr_data = 0; map_mask = 0;
    endtask

    task automatic cfg_data(logic [7:0] v);
        @(negedge clk);
        idle();
        cfg_we = 1; cfg_sel = 1; cfg_wdata = v;
        @(posedge clk); #1;
        case (m_idx)
            3'd0: m_mask  = v;
            3'd1: m_dc    = v[3:0];
            3'd2: m_col   = v[3:0];
            3'd3: m_mode  = v[1:0];
            3'd4: m_rdmap = v[1:0];
            default: ;
        endcase
        idle();
    endtask

    task automatic do_cfg(logic [2:0] ix, logic [7:0] v);
        @(negedge clk);
        idle();
        cfg_we = 1; cfg_sel = 0; cfg_wdata = {5'b10110, ix};
        @(posedge clk); #1;
        m_idx = ix;
        cfg_data(v);
    endtask

    task automatic do_read(logic cmp, string tag);
        logic [7:0] e;
        @(negedge clk);
        idle();
        rd_en = 1; rd_cmp = cmp; rd_planes = m_mem;
        e = cmp ? exp_cmp(m_mem, m_dc, m_col) : m_mem[8*m_rdmap +: 8];
        #2;
        chk(tag, rd_result === e, {24'h0, rd_result}, {24'h0, e});
        @(posedge clk); #1;
        m_latch = m_mem;
        idle();
    endtask

    task automatic do_write(logic [7:0] d, logic [3:0] mm, string tag);
        logic [31:0] e;
        @(negedge clk);
        idle();
        wr_en = 1; wr_data = d; map_mask = mm;
        e = exp_write(m_mode, m_mask, m_col, m_latch, d);
        #2;
        chk({tag, " strobe R9"}, fb_we === mm, {28'h0, fb_we}, {28'h0, mm});
        chk(tag, fb_wdata === e, fb_wdata, e);
        @(posedge clk); #1;
        for (int p = 0; p < 4; p++)
            if (mm[p]) m_mem[8*p +: 8] = e[8*p +: 8];
        idle();
    endtask

    function automatic string mode_tag(logic [1:0] md);
        case (md)
            2'd0: return "R3/R6 mode0";
            2'd1: return "R5 mode1";
            2'd2: return "R3/R7 mode2";
            default: return "R3/R8 mode3";
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        idle();
        rst = 1;
        m_idx = 0; m_mask = 8'hFF; m_dc = 0; m_col = 0; m_mode = 0; m_rdmap = 0;
        m_latch = 0; m_mem = 32'hC3_5A_0F_96;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state seen through the ports
        @(negedge clk); #2;
        chk("R1 idle strobe", fb_we === 4'b0, {28'h0, fb_we}, 32'h0);
        do_write(8'h5A, 4'hF, "R1 default mask/mode");
        do_cfg(3'd3, 8'h01);
        do_write(8'hFF, 4'hF, "R1 latches cleared");
        do_read(1'b1, "R1 dont-care cleared R10");
        do_cfg(3'd3, 8'h00);

        // R2: index retention and unused indices
        do_cfg(3'd0, 8'h0F);
        cfg_data(8'hF0);
        do_read(1'b0, "R11 plane0");
        do_write(8'hAA, 4'hF, "R2 index kept");
        do_cfg(3'd6, 8'h00);
        cfg_data(8'h33);
        do_write(8'h55, 4'hF, "R2 unused index ignored");

        // R4: write before and after a read
        do_cfg(3'd0, 8'h00);
        m_mem = 32'h12_34_56_78;
        do_write(8'hFF, 4'hF, "R4 stale latch");
        do_read(1'b0, "R11 read");
        do_write(8'hFF, 4'hF, "R4 fresh latch");

        // R5, R7, R8 directed
        do_cfg(3'd0, 8'h3C);
        do_cfg(3'd3, 8'h01);
        do_write(8'hFF, 4'hF, "R5 mask ignored");
        do_cfg(3'd3, 8'h02);
        do_cfg(3'd0, 8'hFF);
        do_write(8'hA5, 4'hF, "R7 expand");
        do_cfg(3'd2, 8'h0A);
        do_cfg(3'd3, 8'h03);
        do_write(8'h6B, 4'hF, "R8 colour and");

        // R9 strobe gating
        do_cfg(3'd3, 8'h00);
        do_write(8'h11, 4'h0, "R9 no plane");
        do_write(8'h22, 4'hA, "R9 planes 1,3");
        do_read(1'b0, "R9 untouched planes R11");

        // R10 compare, R11 plane select
        do_cfg(3'd1, 8'hF0);
        do_read(1'b1, "R10 reserved dc bits");
        do_cfg(3'd1, 8'h05);
        do_cfg(3'd2, 8'h04);
        do_read(1'b1, "R10 partial compare");
        do_cfg(3'd4, 8'h02);
        do_read(1'b0, "R11 plane2");
        do_cfg(3'd4, 8'h03);
        do_read(1'b0, "R11 plane3");

        // random mix
        for (int n = 0; n < 800; n++) begin
            int r;
            r = $urandom % 12;
            if (r < 2)        do_cfg(3'($urandom), 8'($urandom));
            else if (r == 2)  cfg_data(8'($urandom));
            else if (r < 5)   do_read(1'b0, "R11/R4 random read");
            else if (r < 7)   do_read(1'b1, "R10 random compare");
            else if (r == 7)  m_mem = $urandom;
            else              do_write(8'($urandom), 4'($urandom), mode_tag(m_mode));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule